// File: doc/BRIEF.md
# Completion Interrupt Credit Moderator

This block decides when a single descriptor ring may raise its completion interrupt. It keeps a count of completed descriptors that software has not yet handled. Each hardware completion strobe adds one to that count. Software hands handled work back by writing a credit return value, which is subtracted from the count. The block owns an automatic mask that is separate from any per-vector mask in the message table. Firing an interrupt sets this automatic mask. Only a return that clears the count reopens it.

The request output is a one-cycle pulse. It carries the vector number of the ring, which is worked out from the ring index. The command ring and the event ring take the lowest vectors. The data rings start above a gap that is kept for the test-completion vector and one spare. Message generation and pending-bit tracking are handled elsewhere and only consume `irq_req` and `irq_vec`.

Top module: `irq_credit_mod`

## Requirements
- R1: After a synchronous active-high reset, `credits` is 0, `auto_masked` is 0 and `irq_req` is 0.
- R2: Each cycle with `cmpl_strobe` high and no credit return adds exactly one to `credits`. The count holds at its maximum, 2^CREDIT_W-1, and does not wrap.
- R3: A completion while `auto_masked` is 0 produces a single `irq_req` pulse in the following cycle, and `auto_masked` reads 1 from that cycle on.
- R4: Completions while `auto_masked` is 1 (with no return) only increase the count and never raise `irq_req`.
- R5: A credit return (`ret_valid` high) subtracts `ret_credits` from the count. A return larger than the count leaves the count at 0.
- R6: A return that leaves the count at 0 clears `auto_masked` and raises no `irq_req`.
- R7: A return that leaves the count above 0 raises `irq_req` one cycle later, and `auto_masked` stays 1.
- R8: A completion and a return in the same cycle are both applied: one is added, then the return is subtracted. The fire or unmask decision follows the resulting count as in R6 and R7. This holds even for a return of 0.
- R9: `irq_vec` is valid while `irq_req` is high. Ring 0 maps to vector 0 and ring 1 to vector 1. Any ring r of 2 or more maps to vector r+2, so transmit rings (even r) take even vectors and receive rings take odd ones. Vectors 2 and 3 are never produced.
- R10: A return while `auto_masked` is 0 leaves the count at 0, leaves the mask open and raises no `irq_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_idx | input | 7 | Index of the ring served by this instance |
| cmpl_strobe | input | 1 | One descriptor marked complete this cycle |
| ret_valid | input | 1 | Software credit return write this cycle |
| ret_credits | input | CREDIT_W | Number of credits returned |
| credits | output | CREDIT_W | Current outstanding count, as read by software |
| auto_masked | output | 1 | Automatic interrupt mask state |
| irq_req | output | 1 | One-cycle interrupt request pulse |
| irq_vec | output | 8 | Vector number accompanying `irq_req` |

## Verification
The hardest cases to reach are a completion and a credit return landing in the same cycle while the mask is already set. The interesting ones are where the combined result lands exactly on zero, or leaves a remainder because the return was zero. The stimulus first fires the ring so that the mask is closed. It then drives both strobes together on a single clock with return values chosen to hit each outcome. The saturated count is reached by issuing more completions than the counter can hold on a narrowed credit width, and then returning all of them at once.

// File: rtl/icm_pkg.sv
package icm_pkg;

    localparam int RING_W = 7;
    localparam int VEC_W  = 8;

    typedef enum logic {
        MS_OPEN   = 1'b0,
        MS_MASKED = 1'b1
    } mask_state_e;

    typedef struct packed {
        logic             fire;
        logic [VEC_W-1:0] vec;
    } irq_evt_t;

    // Command and event rings sit at the bottom; data rings skip two slots.
    function automatic logic [VEC_W-1:0] ring_vector(input logic [RING_W-1:0] ring);
        logic [VEC_W-1:0] wide;
        wide = {{(VEC_W-RING_W){1'b0}}, ring};
        if (wide < VEC_W'(2))
            return wide;
        return wide + VEC_W'(2);
    endfunction

endpackage

// File: rtl/icm_credit_counter.sv
module icm_credit_counter #(
    parameter int CREDIT_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                inc,
    input  logic                dec_valid,
    input  logic [CREDIT_W-1:0] dec_amt,
    output logic [CREDIT_W-1:0] count,
    output logic                next_zero
);

    localparam logic [CREDIT_W:0] MAX_EXT = {1'b0, {CREDIT_W{1'b1}}};

    logic [CREDIT_W:0] sum_ext;
    logic [CREDIT_W:0] take_ext;
    logic [CREDIT_W:0] nxt_ext;

    always_comb begin
        sum_ext = {1'b0, count} + {{CREDIT_W{1'b0}}, inc};
        if (sum_ext > MAX_EXT)
            sum_ext = MAX_EXT;
        take_ext = dec_valid ? {1'b0, dec_amt} : '0;
        nxt_ext  = (take_ext >= sum_ext) ? '0 : (sum_ext - take_ext);
    end

    assign next_zero = (nxt_ext == '0);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else
            count <= nxt_ext[CREDIT_W-1:0];
    end

    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        (inc && !dec_valid && count != MAX_EXT[CREDIT_W-1:0])
        |=> (count == $past(count) + CREDIT_W'(1)));

    assert_count_hold_max_R2: assert property (@(posedge clk) disable iff (rst)
        (inc && !dec_valid && count == MAX_EXT[CREDIT_W-1:0])
        |=> (count == MAX_EXT[CREDIT_W-1:0]));

    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !inc && dec_amt >= count) |=> (count == '0));

endmodule

// File: rtl/icm_automask.sv
module icm_automask
    import icm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmpl,
    input  logic             ret_valid,
    input  logic             cnt_next_zero,
    input  logic [VEC_W-1:0] vec_in,
    output logic             masked,
    output irq_evt_t         evt
);

    mask_state_e state;
    mask_state_e state_nxt;
    logic        fire_nxt;

    always_comb begin
        state_nxt = state;
        fire_nxt  = 1'b0;
        if (ret_valid) begin
            if (cnt_next_zero) begin
                state_nxt = MS_OPEN;
            end else begin
                state_nxt = MS_MASKED;
                fire_nxt  = 1'b1;
            end
        end else if (cmpl && state == MS_OPEN) begin
            state_nxt = MS_MASKED;
            fire_nxt  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= MS_OPEN;
            evt.fire <= 1'b0;
            evt.vec  <= '0;
        end else begin
            state    <= state_nxt;
            evt.fire <= fire_nxt;
            if (fire_nxt)
                evt.vec <= vec_in;
        end
    end

    assign masked = (state == MS_MASKED);

    assert_fire_masks_R3: assert property (@(posedge clk) disable iff (rst)
        evt.fire |-> masked);

    assert_masked_silent_R4: assert property (@(posedge clk) disable iff (rst)
        (cmpl && !ret_valid && masked) |=> (!evt.fire && masked));

    assert_unmask_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(masked) |-> !evt.fire);

    assert_remainder_fires_R7: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && !cnt_next_zero) |=> (evt.fire && masked));

endmodule

// File: rtl/irq_credit_mod.sv
module irq_credit_mod
    import icm_pkg::*;
#(
    parameter int CREDIT_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [6:0]          ring_idx,
    input  logic                cmpl_strobe,
    input  logic                ret_valid,
    input  logic [CREDIT_W-1:0] ret_credits,
    output logic [CREDIT_W-1:0] credits,
    output logic                auto_masked,
    output logic                irq_req,
    output logic [7:0]          irq_vec
);

    logic       next_zero;
    irq_evt_t   evt;
    logic [7:0] ring_vec;

    assign ring_vec = ring_vector(ring_idx);

    icm_credit_counter #(.CREDIT_W(CREDIT_W)) u_count (
        .clk       (clk),
        .rst       (rst),
        .inc       (cmpl_strobe),
        .dec_valid (ret_valid),
        .dec_amt   (ret_credits),
        .count     (credits),
        .next_zero (next_zero)
    );

    icm_automask u_mask (
        .clk           (clk),
        .rst           (rst),
        .cmpl          (cmpl_strobe),
        .ret_valid     (ret_valid),
        .cnt_next_zero (next_zero),
        .vec_in        (ring_vec),
        .masked        (auto_masked),
        .evt           (evt)
    );

    assign irq_req = evt.fire;
    assign irq_vec = evt.vec;

    // An open mask always means nothing is outstanding.
    assert_open_means_empty_R10: assert property (@(posedge clk) disable iff (rst)
        !auto_masked |-> (credits == '0));

    assert_vec_not_reserved_R9: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (irq_vec != 8'd2 && irq_vec != 8'd3));

endmodule

// File: tb/irq_credit_mod_test.sv
`timescale 1ns/1ps
module irq_credit_mod_test;

    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [6:0]    ring_idx = '0;
    logic          cmpl_strobe = 1'b0;
    logic          ret_valid = 1'b0;
    logic [CW-1:0] ret_credits = '0;
    logic [CW-1:0] credits;
    logic          auto_masked;
    logic          irq_req;
    logic [7:0]    irq_vec;

    int total = 0;
    int fails = 0;

    always #2 clk = ~clk;

    irq_credit_mod #(.CREDIT_W(CW)) uut (
        .clk(clk), .rst(rst), .ring_idx(ring_idx),
        .cmpl_strobe(cmpl_strobe), .ret_valid(ret_valid), .ret_credits(ret_credits),
        .credits(credits), .auto_masked(auto_masked),
        .irq_req(irq_req), .irq_vec(irq_vec)
    );

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // Drive one clock worth of inputs, then sample at the following negedge.
    task automatic tick(input logic c, input logic rv, input int rc);
        cmpl_strobe = c;
        ret_valid   = rv;
        ret_credits = CW'(rc);
        @(posedge clk);
        @(negedge clk);
        cmpl_strobe = 1'b0;
        ret_valid   = 1'b0;
        ret_credits = '0;
    endtask

    task automatic expect_state(input string tag, input int c, input int m, input int q);
        chk({tag, " credits"}, int'(credits), c);
        chk({tag, " mask"}, int'(auto_masked), m);
        chk({tag, " irq"}, int'(irq_req), q);
    endtask

    task automatic t_reset;
        expect_state("R1 reset", 0, 0, 0);
    endtask

    task automatic t_first_fire;
        ring_idx = 7'd5;
        tick(1, 0, 0);
        expect_state("R3 first completion", 1, 1, 1);
        chk("R9 vector ring5", int'(irq_vec), 7);
        tick(0, 0, 0);
        expect_state("R3 single pulse", 1, 1, 0);
    endtask

    task automatic t_masked_completions;
        for (int i = 0; i < 3; i++) begin
            tick(1, 0, 0);
            chk("R4 no irq while masked", int'(irq_req), 0);
        end
        expect_state("R2 count after masked adds", 4, 1, 0);
    endtask

    task automatic t_partial_return;
        tick(0, 1, 3);
        expect_state("R7 partial return", 1, 1, 1);
        tick(0, 1, 1);
        expect_state("R6 full return", 0, 0, 0);
    endtask

    task automatic t_return_open;
        tick(0, 1, 5);
        expect_state("R10 return while open", 0, 0, 0);
    endtask

    task automatic t_over_return;
        tick(1, 0, 0);
        tick(1, 0, 0);
        tick(1, 0, 0);
        expect_state("R2 three adds", 3, 1, 0);
        tick(0, 1, 9);
        expect_state("R5 over-return clamps", 0, 0, 0);
    endtask

    task automatic t_saturate;
        for (int i = 0; i < 21; i++) tick(1, 0, 0);
        expect_state("R2 saturation", 15, 1, 0);
        tick(0, 1, 15);
        expect_state("R6 return all from max", 0, 0, 0);
    endtask

    task automatic t_simultaneous;
        tick(1, 0, 0);
        expect_state("R8 setup fire", 1, 1, 1);
        tick(1, 1, 1);
        expect_state("R8 add and return leave one", 1, 1, 1);
        tick(1, 1, 2);
        expect_state("R8 add and return reach zero", 0, 0, 0);
        tick(1, 1, 0);
        expect_state("R8 add with zero return", 1, 1, 1);
        tick(0, 1, 1);
        expect_state("R8 cleanup", 0, 0, 0);
    endtask

    task automatic t_vectors;
        int rings[4] = '{0, 1, 2, 127};
        int vecs[4]  = '{0, 1, 4, 129};
        for (int i = 0; i < 4; i++) begin
            ring_idx = 7'(rings[i]);
            tick(1, 0, 0);
            chk("R9 vector irq", int'(irq_req), 1);
            chk("R9 vector map", int'(irq_vec), vecs[i]);
            tick(0, 1, 1);
        end
        ring_idx = 7'd6;
        tick(1, 0, 0);
        chk("R9 tx ring even vector", int'(irq_vec), 8);
        tick(0, 1, 1);
    endtask

    initial begin
        #100000;
        fails++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        rst = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_first_fire();
        t_masked_completions();
        t_partial_return();
        t_return_open();
        t_over_return();
        t_saturate();
        t_simultaneous();
        t_vectors();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule